// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Selector with Paired Issue

This block sits between an instruction fetch buffer and the decoders of a processor whose instructions are 16, 32, 64 or 96 bits long. Each cycle it receives one 128-bit fetch line, aligned on a 16-byte boundary, and a count of how many halfwords at the start of that line hold valid data. An internal byte pointer selects the halfword where the next instruction starts. The block reads the length of that instruction from its first halfword and puts the whole instruction into a wide slot. When both the first and the following instruction are 32 bits long and the first one starts on a 4-byte boundary, it puts the second instruction into a second slot. It then moves the pointer forward by the bytes it has issued.

If the instruction at the pointer does not fit in the valid part of the line, nothing is issued. The block raises a stall flag and keeps the pointer where it is until more data arrives. The upstream buffer drives the line that contains the pointer, using the pointer output as its address. All results are registered, so the result for the line seen at a clock edge appears on the outputs just after that edge.

Top module: `fv_sel`

## Requirements
- R1: Length comes from the first halfword of the instruction. If bits [1:0] are not 11, the instruction is 16 bits long. If bits [1:0] are 11 and bits [4:2] are not 111, it is 32 bits long. If bits [4:0] are 11111, it is 64 bits long when bit 5 is 0 and 96 bits long when bit 5 is 1. `slot0_len` reports the length as 0=16, 1=32, 2=64, 3=96.
- R2: Instructions start only on halfword boundaries, so `ptr` bit 0 is always 0. The window offset is `ptr[3:1]`. `slot0_data` holds the issued halfwords in address order, starting at bit 0, and every bit above the instruction is zero.
- R3: A 64-bit instruction fills `slot0_data[63:0]` and a 96-bit instruction fills `slot0_data[95:0]`, built from four or six consecutive halfwords of the line.
- R4: A second instruction is issued in `slot1_data` only when the first instruction is 32 bits long, starts at a byte address with bits [1:0] equal to 00, and the next instruction is also 32 bits long.
- R5: A 16-, 64- or 96-bit instruction always issues alone, and so does a 32-bit instruction that starts at an address with bit 1 set.
- R6: The second slot is valid only when the second instruction lies entirely inside the valid halfwords. Otherwise the first instruction issues alone.
- R7: When the first instruction reaches past the last valid halfword (a short valid count, the end of the line, or a count of 0), both slot valid flags are 0, `stall` is 1 and `ptr` keeps its value.
- R8: `ptr` moves forward by the bytes issued: 2, 4, 8 or 12 for one instruction, and 8 for a pair.
- R9: A synchronous active-high `rst` clears both slot valid flags and `stall`, and sets `ptr` to 0.
- R10: The outputs are registered. The line and valid count seen at a rising edge determine the outputs that appear after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_data | input | 128 | Fetch line holding `ptr`; halfword k sits at bits [16k+15:16k] |
| win_hw_vld | input | 4 | Number of valid halfwords from the start of the line (0 to 8) |
| slot0_vld | output | 1 | Older instruction slot is valid |
| slot0_len | output | 2 | Length code of the slot 0 instruction |
| slot0_data | output | 96 | Older instruction, zero above its length |
| slot1_vld | output | 1 | Paired second 32-bit instruction is valid |
| slot1_data | output | 32 | Second 32-bit instruction |
| stall | output | 1 | First instruction does not fit in the valid data |
| ptr | output | 16 | Byte address of the next instruction |

## Verification
A program of mixed instructions is walked across four lines. It contains an aligned 32+32 pair, a 32-bit instruction at a halfword-only address, a 32-bit instruction followed by a 16-bit one, and a 32-bit instruction whose partner lies in the next line. These cases separate the pairing conditions from one another. The 64- and 96-bit instructions check that wide slots are assembled from the correct halfwords and that the pointer steps by 8 and 12. Short valid counts check the difference between a partner that is cut off, which still issues one instruction, and a first instruction that is cut off, which stalls. An instruction that crosses the end of the line, a line with no valid data, and a reset in the middle of a run check holding and clearing of the pointer.

// File: rtl/fv_sel_pkg.sv
package fv_sel_pkg;

    typedef enum logic [1:0] {
        LEN16 = 2'd0,
        LEN32 = 2'd1,
        LEN64 = 2'd2,
        LEN96 = 2'd3
    } ilen_e;

    // halfword count of each length class
    function automatic logic [2:0] ilen_hw(ilen_e l);
        case (l)
            LEN16:   return 3'd1;
            LEN32:   return 3'd2;
            LEN64:   return 3'd4;
            default: return 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/fv_len_dec.sv
module fv_len_dec
    import fv_sel_pkg::*;
(
    input  logic [15:0] head,
    output ilen_e       len
);

    always_comb begin
        if (head[1:0] != 2'b11) begin
            len = LEN16;
        end else if (head[4:2] != 3'b111) begin
            len = LEN32;
        end else if (head[5]) begin
            len = LEN96;
        end else begin
            len = LEN64;
        end
    end

endmodule

// File: rtl/fv_hw_window.sv
module fv_hw_window #(
    parameter int WIN_HW = 8,
    parameter int OUT_HW = 6,
    parameter int OFF_W  = 3
) (
    input  logic [WIN_HW*16-1:0] win,
    input  logic [OFF_W-1:0]     off,
    output logic [OUT_HW*16-1:0] hws
);

    // halfword k of the output is line halfword off+k, zero past the line end
    always_comb begin
        hws = '0;
        for (int k = 0; k < OUT_HW; k++) begin
            for (int j = 0; j < WIN_HW; j++) begin
                if (j == int'(off) + k) begin
                    hws[k*16 +: 16] = win[j*16 +: 16];
                end
            end
        end
    end

endmodule

// File: rtl/fv_sel.sv
module fv_sel
    import fv_sel_pkg::*;
#(
    parameter int WIN_HW = 8,
    parameter int AW     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [WIN_HW*16-1:0]       win_data,
    input  logic [$clog2(WIN_HW+1)-1:0] win_hw_vld,
    output logic                       slot0_vld,
    output logic [1:0]                 slot0_len,
    output logic [95:0]                slot0_data,
    output logic                       slot1_vld,
    output logic [31:0]                slot1_data,
    output logic                       stall,
    output logic [AW-1:0]              ptr
);

    localparam int OFF_W    = $clog2(WIN_HW);
    localparam int CNT_W    = $clog2(WIN_HW + 1);
    localparam int MAX_HW   = 6;
    localparam int PAIR_HW  = 4;
    localparam int PAIR_ADD = 4;

    typedef struct packed {
        logic               s0_vld;
        ilen_e              s0_len;
        logic [MAX_HW*16-1:0] s0_data;
        logic               s1_vld;
        logic [31:0]        s1_data;
        logic               stall;
        logic [AW-1:0]      ptr;
    } st_t;

    st_t st_d, st_q;

    logic [OFF_W-1:0]      off;
    logic [MAX_HW*16-1:0]  hw;
    ilen_e                 len0, len1;
    logic [CNT_W-1:0]      avail;
    logic [CNT_W-1:0]      n0;
    logic                  fit0, pair;
    logic [AW-1:0]         step;

    assign off = st_q.ptr[OFF_W:1];

    fv_hw_window #(
        .WIN_HW (WIN_HW),
        .OUT_HW (MAX_HW),
        .OFF_W  (OFF_W)
    ) u_win (
        .win (win_data),
        .off (off),
        .hws (hw)
    );

    fv_len_dec u_dec0 (.head(hw[15:0]),  .len(len0));
    fv_len_dec u_dec1 (.head(hw[47:32]), .len(len1));

    // halfwords still valid from the pointer onward
    always_comb begin
        if (win_hw_vld > CNT_W'(off)) begin
            avail = win_hw_vld - CNT_W'(off);
        end else begin
            avail = '0;
        end
    end

    always_comb begin
        n0   = CNT_W'(ilen_hw(len0));
        fit0 = (n0 <= avail);
        pair = fit0 && (len0 == LEN32) && (len1 == LEN32)
               && !st_q.ptr[1] && (avail >= CNT_W'(PAIR_HW));
        step = AW'({n0, 1'b0}) + (pair ? AW'(PAIR_ADD) : AW'(0));
    end

    always_comb begin
        st_d         = st_q;
        st_d.s0_vld  = 1'b0;
        st_d.s0_len  = LEN16;
        st_d.s0_data = '0;
        st_d.s1_vld  = 1'b0;
        st_d.s1_data = '0;
        st_d.stall   = 1'b0;
        if (fit0) begin
            st_d.s0_vld = 1'b1;
            st_d.s0_len = len0;
            for (int k = 0; k < MAX_HW; k++) begin
                if (CNT_W'(k) < n0) begin
                    st_d.s0_data[k*16 +: 16] = hw[k*16 +: 16];
                end
            end
            if (pair) begin
                st_d.s1_vld  = 1'b1;
                st_d.s1_data = hw[63:32];
            end
            st_d.ptr = st_q.ptr + step;
        end else begin
            st_d.stall = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot0_vld  = st_q.s0_vld;
    assign slot0_len  = st_q.s0_len;
    assign slot0_data = st_q.s0_data;
    assign slot1_vld  = st_q.s1_vld;
    assign slot1_data = st_q.s1_data;
    assign stall      = st_q.stall;
    assign ptr        = st_q.ptr;

endmodule

// File: rtl/fv_sel_chk.sv
module fv_sel_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          slot0_vld,
    input logic [1:0]    slot0_len,
    input logic          slot1_vld,
    input logic          stall,
    input logic [AW-1:0] ptr
);

    logic [AW-1:0] exp_step;

    always_comb begin
        case (slot0_len)
            2'd0:    exp_step = AW'(2);
            2'd1:    exp_step = AW'(4);
            2'd2:    exp_step = AW'(8);
            default: exp_step = AW'(12);
        endcase
        if (slot1_vld) begin
            exp_step = exp_step + AW'(4);
        end
    end

    a_r2_even_ptr: assert property (@(posedge clk) disable iff (rst)
        ptr[0] == 1'b0);

    a_r4_pair_aligned: assert property (@(posedge clk) disable iff (rst)
        slot1_vld |-> (slot0_vld && slot0_len == 2'd1 && $past(ptr[1]) == 1'b0));

    a_r7_stall_holds: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!slot0_vld && !slot1_vld && ptr == $past(ptr)));

    a_r8_advance: assert property (@(posedge clk) disable iff (rst)
        slot0_vld |-> (ptr == $past(ptr) + exp_step));

    a_r9_reset: assert property (@(posedge clk)
        rst |=> (!slot0_vld && !slot1_vld && !stall && ptr == '0));

endmodule

bind fv_sel fv_sel_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot0_vld (slot0_vld),
    .slot0_len (slot0_len),
    .slot1_vld (slot1_vld),
    .stall     (stall),
    .ptr       (ptr)
);

// File: tb/tb_fv_sel.sv
`timescale 1ns/1ps
module tb_fv_sel;

    localparam int NL = 4;
    localparam int NV = 15;

    logic         clk = 1'b0;
    logic         rst;
    logic [127:0] win_data;
    logic [3:0]   win_hw_vld;
    logic         slot0_vld, slot1_vld, stall;
    logic [1:0]   slot0_len;
    logic [95:0]  slot0_data;
    logic [31:0]  slot1_data;
    logic [15:0]  ptr;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [NL*8];

    always #4 clk = ~clk;

    fv_sel dut (
        .clk(clk), .rst(rst), .win_data(win_data), .win_hw_vld(win_hw_vld),
        .slot0_vld(slot0_vld), .slot0_len(slot0_len), .slot0_data(slot0_data),
        .slot1_vld(slot1_vld), .slot1_data(slot1_data), .stall(stall), .ptr(ptr)
    );

    // {s0_vld, len, s1_vld, stall, ptr_before, ptr_after}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 2'd1, 1'b1, 1'b0, 8'd0,  8'd8},
        {1'b1, 2'd0, 1'b0, 1'b0, 8'd8,  8'd10},
        {1'b1, 2'd1, 1'b0, 1'b0, 8'd10, 8'd14},
        {1'b1, 2'd0, 1'b0, 1'b0, 8'd14, 8'd16},
        {1'b1, 2'd1, 1'b0, 1'b0, 8'd16, 8'd20},
        {1'b1, 2'd0, 1'b0, 1'b0, 8'd20, 8'd22},
        {1'b1, 2'd0, 1'b0, 1'b0, 8'd22, 8'd24},
        {1'b1, 2'd1, 1'b1, 1'b0, 8'd24, 8'd32},
        {1'b1, 2'd2, 1'b0, 1'b0, 8'd32, 8'd40},
        {1'b1, 2'd0, 1'b0, 1'b0, 8'd40, 8'd42},
        {1'b1, 2'd0, 1'b0, 1'b0, 8'd42, 8'd44},
        {1'b1, 2'd1, 1'b0, 1'b0, 8'd44, 8'd48},
        {1'b1, 2'd3, 1'b0, 1'b0, 8'd48, 8'd60},
        {1'b1, 2'd1, 1'b0, 1'b0, 8'd60, 8'd64},
        {1'b0, 2'd0, 1'b0, 1'b1, 8'd64, 8'd64}
    };

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < NL*8; i++) mem[i] = 16'h7700 + 16'(i);
    endtask

    // drive the line holding the current pointer, limited to lim valid halfwords
    task automatic apply(input int lim);
        int line;
        line = int'(ptr[15:4]);
        win_data = '0;
        if (line < NL) begin
            for (int k = 0; k < 8; k++) win_data[k*16 +: 16] = mem[line*8 + k];
            win_hw_vld = 4'(lim);
        end else begin
            win_hw_vld = 4'd0;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        win_hw_vld = 4'd0;
        win_data = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [95:0] exp_s0(input int b, input int lc);
        logic [95:0] e;
        int n;
        n = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 2) ? 4 : 6;
        e = '0;
        for (int k = 0; k < n; k++) e[k*16 +: 16] = mem[b + k];
        return e;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R9 reset state
        chk("R9 slot0_vld", 96'(slot0_vld), 96'(0));
        chk("R9 slot1_vld", 96'(slot1_vld), 96'(0));
        chk("R9 stall", 96'(stall), 96'(0));
        chk("R9 ptr", 96'(ptr), 96'(0));

        // program image: heads per R1 encoding
        clear_mem();
        mem[0]  = 16'hA003; mem[2]  = 16'hA007;   // aligned pair (R4)
        mem[4]  = 16'h1230;                       // 16-bit
        mem[5]  = 16'hA00B;                       // 32-bit at bit1 set (R5)
        mem[7]  = 16'h4444;                       // 16-bit
        mem[8]  = 16'hA003; mem[10] = 16'h1231;   // 32 then 16: no pair (R4)
        mem[11] = 16'h1232;
        mem[12] = 16'hA013; mem[14] = 16'hA017;   // aligned pair
        mem[16] = 16'hC01F;                       // 64-bit (R3)
        mem[20] = 16'h0000; mem[21] = 16'h1234;
        mem[22] = 16'hA003;                       // partner outside line (R6)
        mem[24] = 16'hD03F;                       // 96-bit (R3)
        mem[30] = 16'hA01B;                       // last halfword pair of line

        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            int b;
            v = VEC[i];
            b = int'(v[15:8]) / 2;
            apply(8);
            step();  // R10: result appears after the edge
            chk("R5 slot0_vld", 96'(slot0_vld), 96'(v[20]));
            chk("R4 slot1_vld", 96'(slot1_vld), 96'(v[17]));
            chk("R7 stall", 96'(stall), 96'(v[16]));
            chk("R8 ptr", 96'(ptr), 96'(v[7:0]));
            if (v[20]) begin
                chk("R1 slot0_len", 96'(slot0_len), 96'(v[19:18]));
                chk("R2 slot0_data", slot0_data, exp_s0(b, int'(v[19:18])));
            end
            if (v[17]) chk("R4 slot1_data", 96'(slot1_data), 96'({mem[b+3], mem[b+2]}));
        end

        // R7: 64-bit head with only three valid halfwords, then four
        do_reset();
        clear_mem();
        mem[0] = 16'hC01F;
        apply(3); step();
        chk("R7 short stall", 96'(stall), 96'(1));
        chk("R7 short no slot", 96'(slot0_vld), 96'(0));
        chk("R7 short ptr held", 96'(ptr), 96'(0));
        apply(4); step();
        chk("R3 64 len", 96'(slot0_len), 96'(2));
        chk("R3 64 data", slot0_data, exp_s0(0, 2));
        chk("R8 64 ptr", 96'(ptr), 96'(8));

        // R6: pair candidates with only three valid halfwords
        do_reset();
        clear_mem();
        mem[0] = 16'hA003; mem[2] = 16'hA003;
        apply(3); step();
        chk("R6 single slot0", 96'(slot0_vld), 96'(1));
        chk("R6 no slot1", 96'(slot1_vld), 96'(0));
        chk("R6 ptr", 96'(ptr), 96'(4));
        apply(3); step();
        chk("R7 cut second stall", 96'(stall), 96'(1));
        chk("R7 cut second ptr", 96'(ptr), 96'(4));

        // R3/R7: 96-bit, 16-bit, then 32-bit crossing the line end
        do_reset();
        clear_mem();
        mem[0] = 16'hD03F; mem[6] = 16'h0004; mem[7] = 16'hA003;
        apply(8); step();
        chk("R3 96 len", 96'(slot0_len), 96'(3));
        chk("R3 96 data", slot0_data, exp_s0(0, 3));
        chk("R8 96 ptr", 96'(ptr), 96'(12));
        apply(8); step();
        chk("R5 16 alone", 96'(slot1_vld), 96'(0));
        chk("R8 16 ptr", 96'(ptr), 96'(14));
        apply(8); step();
        chk("R7 cross stall", 96'(stall), 96'(1));
        chk("R7 cross ptr", 96'(ptr), 96'(14));
        apply(8); step();
        chk("R7 cross still held", 96'(ptr), 96'(14));

        // R9: reset in the middle of a run
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R9 mid stall", 96'(stall), 96'(0));
        chk("R9 mid slot0", 96'(slot0_vld), 96'(0));
        chk("R9 mid ptr", 96'(ptr), 96'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule